// File: doc/BRIEF.md
# Opcode Group Decoder for a Small 8-bit Processor

This block turns the first byte of an instruction into the steering information that the cycle sequencer and the control matrices of a small 8-bit processor need. The first byte comes straight from the instruction latch. The block is purely combinational, so its outputs follow the opcode within the same cycle.

It produces four kinds of output:
- a one-hot vector that names the instruction class;
- a few coarse group flags;
- memory-operand flags, raised when an operand field means "memory addressed by HL";
- two fetch-length flags and an extra-execution-cycle flag.

The raw operand and function fields are also passed through, so that the register file and the ALU can take their selects directly.

The instruction set covered is small:
- register moves, and moves between a register and memory;
- move-immediate, to a register or to memory;
- arithmetic/logic operations with a register, memory or immediate operand;
- load and store of the accumulator at a direct address;
- increment and decrement of HL;
- halt.

Every other byte, including 00h, falls into a catch-all class. That class fetches one byte and executes in one cycle.

Register codes in the operand fields are B=000, C=001, D=010, E=011, H=100, L=101 and A=111. Code 110 means memory.

Top module: `opgrp_decoder`

## Requirements
- R1: `class_o` always has exactly one bit set. The bit positions are: 0 other/NOP, 1 register-to-register move, 2 register loaded from memory, 3 memory written from register, 4 move-immediate to register, 5 move-immediate to memory (36h), 6 ALU with register operand, 7 ALU with memory operand, 8 ALU immediate, 9 load accumulator direct (3Ah), 10 store accumulator direct (32h), 11 increment HL (23h), 12 decrement HL (2Bh), 13 halt (76h).
- R2: An opcode of form 01dddsss selects a move class, chosen by whether ddd and sss equal 110 (bit 1, 2 or 3). The one exception is 76h, which selects halt (bit 13).
- R3: An opcode of form 10fffsss selects ALU-with-memory (bit 7) when sss is 110, and ALU-with-register (bit 6) otherwise.
- R4: An opcode of form 11fff110 selects ALU immediate (bit 8). An opcode of form 00ddd110 selects move-immediate, to memory (bit 5) when ddd is 110 and to a register (bit 4) otherwise.
- R5: The opcodes 3Ah, 32h, 23h and 2Bh select load direct, store direct, increment HL and decrement HL respectively.
- R6: Every opcode not covered by R2 to R5, including 00h, selects class bit 0. Such an opcode raises neither fetch flag and does not raise `exec2_o`.
- R7: `dst_sel_o` equals opcode bits [5:3] and `src_sel_o` equals bits [2:0], for every opcode. `alu_fn_o` equals bits [5:3], with the order ADD=0, ADC=1, SUB=2, SBB=3, AND=4, XOR=5, OR=6, CMP=7.
- R8: `mem_src_o` is high exactly for the class "register loaded from memory" and the class "ALU with memory operand". `mem_dst_o` is high exactly for "memory written from register" and "move-immediate to memory".
- R9: `move_grp_o` is high exactly when opcode bits [7:6] are 01, including 76h. `alu_grp_o` is high exactly when they are 10.
- R10: `fetch2_o` is high for both move-immediate classes and for ALU immediate. `fetch3_o` is high for load and store direct. The two flags are never high together.
- R11: `exec2_o` is high exactly for the three ALU classes and for increment and decrement of HL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 8 | First instruction byte from the instruction latch |
| class_o | output | 14 | One-hot instruction class (bit map in R1) |
| move_grp_o | output | 1 | Opcode prefix is 01 |
| alu_grp_o | output | 1 | Opcode prefix is 10 |
| mem_src_o | output | 1 | Source operand is memory addressed by HL |
| mem_dst_o | output | 1 | Destination operand is memory addressed by HL |
| fetch2_o | output | 1 | Instruction is two bytes long |
| fetch3_o | output | 1 | Instruction is three bytes long |
| exec2_o | output | 1 | Instruction needs a second execution cycle |
| dst_sel_o | output | 3 | Destination register field |
| src_sel_o | output | 3 | Source register field |
| alu_fn_o | output | 3 | ALU function field |

## Verification
The assertions take for granted that the opcode is a fully known 8-bit value. While any bit is unknown, they stand aside, and they judge only the settled combinational result.

The bench drives a defined byte from its first cycle onward and never releases the input to an unknown state. It walks every one of the 256 opcodes, then adds seeded random bytes and directed boundary bytes, such as 76h, 36h, 00h and the neighbours of the direct-address encodings.

// File: rtl/opgrp_pkg.sv
package opgrp_pkg;

    localparam int unsigned OP_W      = 8;
    localparam int unsigned FLD_W     = 3;
    localparam int unsigned PFX_W     = OP_W - 2 * FLD_W;
    localparam int unsigned NUM_CLASS = 14;

    localparam logic [FLD_W-1:0] MEM_CODE = 3'b110;

    localparam logic [OP_W-1:0] OP_LDA_D = 8'h3A;
    localparam logic [OP_W-1:0] OP_STA_D = 8'h32;
    localparam logic [OP_W-1:0] OP_INC_HL = 8'h23;
    localparam logic [OP_W-1:0] OP_DEC_HL = 8'h2B;

    typedef enum logic [PFX_W-1:0] {
        PFX_MISC = 2'b00,
        PFX_MOVE = 2'b01,
        PFX_ALU  = 2'b10,
        PFX_IMM  = 2'b11
    } prefix_e;

    typedef enum logic [FLD_W-1:0] {
        FN_ADD = 3'd0,
        FN_ADC = 3'd1,
        FN_SUB = 3'd2,
        FN_SBB = 3'd3,
        FN_AND = 3'd4,
        FN_XOR = 3'd5,
        FN_OR  = 3'd6,
        FN_CMP = 3'd7
    } alu_fn_e;

    typedef enum int unsigned {
        CL_OTHER  = 0,
        CL_MOV_RR = 1,
        CL_MOV_RM = 2,
        CL_MOV_MR = 3,
        CL_MVI_R  = 4,
        CL_MVI_M  = 5,
        CL_ALU_R  = 6,
        CL_ALU_M  = 7,
        CL_ALU_I  = 8,
        CL_LDA_D  = 9,
        CL_STA_D  = 10,
        CL_INC_HL = 11,
        CL_DEC_HL = 12,
        CL_HALT   = 13
    } class_e;

    typedef struct packed {
        prefix_e          pfx;
        logic [FLD_W-1:0] hi;
        logic [FLD_W-1:0] lo;
        logic             hi_mem;
        logic             lo_mem;
    } fields_t;

    // Number of bytes that follow the opcode for a given class.
    function automatic logic [1:0] cls_extra_bytes(input int unsigned c);
        case (c)
            CL_MVI_R, CL_MVI_M, CL_ALU_I: cls_extra_bytes = 2'd1;
            CL_LDA_D, CL_STA_D:           cls_extra_bytes = 2'd2;
            default:                      cls_extra_bytes = 2'd0;
        endcase
    endfunction

    // Classes that need a second execution cycle.
    function automatic logic cls_exec2(input int unsigned c);
        case (c)
            CL_ALU_R, CL_ALU_M, CL_ALU_I, CL_INC_HL, CL_DEC_HL: cls_exec2 = 1'b1;
            default:                                             cls_exec2 = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/opgrp_field_split.sv
module opgrp_field_split
    import opgrp_pkg::*;
(
    input  logic [OP_W-1:0] opcode_i,
    output fields_t         fields_o
);
    always_comb begin
        fields_o.pfx    = prefix_e'(opcode_i[OP_W-1 -: PFX_W]);
        fields_o.hi     = opcode_i[2*FLD_W-1 -: FLD_W];
        fields_o.lo     = opcode_i[FLD_W-1:0];
        fields_o.hi_mem = (opcode_i[2*FLD_W-1 -: FLD_W] == MEM_CODE);
        fields_o.lo_mem = (opcode_i[FLD_W-1:0] == MEM_CODE);
    end
endmodule

// File: rtl/opgrp_classify.sv
module opgrp_classify
    import opgrp_pkg::*;
(
    input  logic [OP_W-1:0]      opcode_i,
    input  fields_t              fields_i,
    output logic [NUM_CLASS-1:0] class_o
);
    logic is_move, is_misc, is_alu, is_imm;
    logic [NUM_CLASS-1:0] known;

    always_comb begin
        is_move = (fields_i.pfx == PFX_MOVE);
        is_misc = (fields_i.pfx == PFX_MISC);
        is_alu  = (fields_i.pfx == PFX_ALU);
        is_imm  = (fields_i.pfx == PFX_IMM);

        known = '0;
        // 01 prefix: three move shapes, with both-memory reserved for halt
        known[CL_MOV_RR] = is_move & ~fields_i.hi_mem & ~fields_i.lo_mem;
        known[CL_MOV_RM] = is_move & ~fields_i.hi_mem &  fields_i.lo_mem;
        known[CL_MOV_MR] = is_move &  fields_i.hi_mem & ~fields_i.lo_mem;
        known[CL_HALT]   = is_move &  fields_i.hi_mem &  fields_i.lo_mem;
        // 00ddd110: move-immediate
        known[CL_MVI_R]  = is_misc &  fields_i.lo_mem & ~fields_i.hi_mem;
        known[CL_MVI_M]  = is_misc &  fields_i.lo_mem &  fields_i.hi_mem;
        // 10 prefix and 11fff110: arithmetic/logic
        known[CL_ALU_R]  = is_alu & ~fields_i.lo_mem;
        known[CL_ALU_M]  = is_alu &  fields_i.lo_mem;
        known[CL_ALU_I]  = is_imm &  fields_i.lo_mem;
        // single encodings
        known[CL_LDA_D]  = (opcode_i == OP_LDA_D);
        known[CL_STA_D]  = (opcode_i == OP_STA_D);
        known[CL_INC_HL] = (opcode_i == OP_INC_HL);
        known[CL_DEC_HL] = (opcode_i == OP_DEC_HL);

        class_o           = known;
        class_o[CL_OTHER] = ~|known;
    end

    always_comb begin
        if (!$isunknown(opcode_i)) begin
            assert_class_onehot_R1: assert ($countones(class_o) == 1)
                else $error("class vector not one-hot: %b", class_o);
            assert_halt_only_76_R2: assert (!class_o[CL_HALT] || opcode_i == 8'h76)
                else $error("halt class on opcode %h", opcode_i);
        end
    end
endmodule

// File: rtl/opgrp_timing.sv
module opgrp_timing
    import opgrp_pkg::*;
(
    input  logic [NUM_CLASS-1:0] class_i,
    output logic                 fetch2_o,
    output logic                 fetch3_o,
    output logic                 exec2_o
);
    logic [NUM_CLASS-1:0] f2_v, f3_v, e2_v;

    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_cls
        localparam logic [1:0] XB = cls_extra_bytes(g);
        localparam logic       E2 = cls_exec2(g);
        assign f2_v[g] = class_i[g] & (XB == 2'd1);
        assign f3_v[g] = class_i[g] & (XB == 2'd2);
        assign e2_v[g] = class_i[g] & E2;
    end

    assign fetch2_o = |f2_v;
    assign fetch3_o = |f3_v;
    assign exec2_o  = |e2_v;

    always_comb begin
        if (!$isunknown(class_i)) begin
            assert_fetch_exclusive_R10: assert (!(fetch2_o && fetch3_o))
                else $error("two- and three-byte flags both high");
            assert_other_single_R6: assert (!class_i[CL_OTHER] || !(fetch2_o || fetch3_o || exec2_o))
                else $error("catch-all class with extended timing");
        end
    end
endmodule

// File: rtl/opgrp_decoder.sv
module opgrp_decoder
    import opgrp_pkg::*;
(
    input  logic [7:0]  opcode_i,
    output logic [13:0] class_o,
    output logic        move_grp_o,
    output logic        alu_grp_o,
    output logic        mem_src_o,
    output logic        mem_dst_o,
    output logic        fetch2_o,
    output logic        fetch3_o,
    output logic        exec2_o,
    output logic [2:0]  dst_sel_o,
    output logic [2:0]  src_sel_o,
    output logic [2:0]  alu_fn_o
);
    fields_t              flds;
    logic [NUM_CLASS-1:0] cls;
    alu_fn_e              fn;

    opgrp_field_split u_split (
        .opcode_i (opcode_i),
        .fields_o (flds)
    );

    opgrp_classify u_class (
        .opcode_i (opcode_i),
        .fields_i (flds),
        .class_o  (cls)
    );

    opgrp_timing u_timing (
        .class_i  (cls),
        .fetch2_o (fetch2_o),
        .fetch3_o (fetch3_o),
        .exec2_o  (exec2_o)
    );

    always_comb begin
        fn         = alu_fn_e'(flds.hi);
        class_o    = cls;
        move_grp_o = (flds.pfx == PFX_MOVE);
        alu_grp_o  = (flds.pfx == PFX_ALU);
        mem_src_o  = cls[CL_MOV_RM] | cls[CL_ALU_M];
        mem_dst_o  = cls[CL_MOV_MR] | cls[CL_MVI_M];
        dst_sel_o  = flds.hi;
        src_sel_o  = flds.lo;
        alu_fn_o   = fn;
    end

    always_comb begin
        if (!$isunknown(opcode_i)) begin
            assert_mem_sides_R8: assert (!(mem_src_o && mem_dst_o))
                else $error("memory source and destination both flagged");
            assert_alu_exec2_R11: assert (!alu_grp_o || exec2_o)
                else $error("ALU group without second execution cycle");
            assert_halt_in_move_R9: assert (!class_o[CL_HALT] || move_grp_o)
                else $error("halt outside move group");
        end
    end
endmodule

// File: tb/opgrp_decoder_tb_top.sv
module opgrp_decoder_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [7:0]  opcode;
    logic [13:0] cls;
    logic mv, al, ms, md, f2, f3, e2;
    logic [2:0] ds, ss, fn;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    opgrp_decoder dut_i (
        .opcode_i (opcode), .class_o (cls),
        .move_grp_o (mv), .alu_grp_o (al),
        .mem_src_o (ms), .mem_dst_o (md),
        .fetch2_o (f2), .fetch3_o (f3), .exec2_o (e2),
        .dst_sel_o (ds), .src_sel_o (ss), .alu_fn_o (fn)
    );

    // Expected class index straight from the requirement text (R1..R6)
    function automatic int exp_class(input logic [7:0] o);
        if (o == 8'h76)                           return 13;
        if (o[7:6] == 2'b01) begin
            if (o[5:3] == 3'b110)                 return 3;
            if (o[2:0] == 3'b110)                 return 2;
            return 1;
        end
        if (o[7:6] == 2'b10)                      return (o[2:0] == 3'b110) ? 7 : 6;
        if (o[7:6] == 2'b11 && o[2:0] == 3'b110)  return 8;
        if (o[7:6] == 2'b00 && o[2:0] == 3'b110)  return (o[5:3] == 3'b110) ? 5 : 4;
        if (o == 8'h3A) return 9;
        if (o == 8'h32) return 10;
        if (o == 8'h23) return 11;
        if (o == 8'h2B) return 12;
        return 0;
    endfunction

    function automatic string class_req(input int c);
        case (c)
            1, 2, 3, 13: return "R2";
            6, 7:        return "R3";
            4, 5, 8:     return "R4";
            9, 10, 11, 12: return "R5";
            default:     return "R6";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [7:0] o, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s opcode=%h actual=%0h expected=%0h", req, what, o, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] o);
        int c;
        logic [13:0] ecls;
        @(posedge clk);
        #1 opcode = o;
        @(negedge clk);
        c = exp_class(o);
        ecls = 14'd1 << c;
        chk(cls == ecls, class_req(c), "class", o, int'(cls), int'(ecls));
        chk($countones(cls) == 1, "R1", "onehot", o, $countones(cls), 1);
        chk(ds == o[5:3] && ss == o[2:0] && fn == o[5:3], "R7", "fields", o,
            int'({ds, ss, fn}), int'({o[5:3], o[2:0], o[5:3]}));
        chk(ms == (c == 2 || c == 7), "R8", "mem_src", o, int'(ms), int'(c == 2 || c == 7));
        chk(md == (c == 3 || c == 5), "R8", "mem_dst", o, int'(md), int'(c == 3 || c == 5));
        chk(mv == (o[7:6] == 2'b01) && al == (o[7:6] == 2'b10), "R9", "groups", o,
            int'({mv, al}), int'({o[7:6] == 2'b01, o[7:6] == 2'b10}));
        chk(f2 == (c == 4 || c == 5 || c == 8) && f3 == (c == 9 || c == 10), "R10", "fetch", o,
            int'({f2, f3}), int'({c == 4 || c == 5 || c == 8, c == 9 || c == 10}));
        chk(e2 == (c == 6 || c == 7 || c == 8 || c == 11 || c == 12), "R11", "exec2", o,
            int'(e2), int'(c == 6 || c == 7 || c == 8 || c == 11 || c == 12));
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        opcode = 8'h00;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-time state: NOP, catch-all class, single byte, single cycle (R6)
        @(negedge clk);
        chk(cls == 14'd1 && !f2 && !f3 && !e2, "R6", "reset nop", 8'h00, int'(cls), 1);
        // directed corners
        apply(8'h76); apply(8'h36); apply(8'h00); apply(8'h3E);
        apply(8'h3A); apply(8'h32); apply(8'h23); apply(8'h2B);
        apply(8'h3B); apply(8'h33); apply(8'h22); apply(8'h2A);
        apply(8'h7E); apply(8'h77); apply(8'h86); apply(8'hC6); apply(8'hFE); apply(8'hFF);
        // full sweep
        for (int i = 0; i < 256; i++) apply(8'(i));
        // seeded random
        seed = 32'h5eed;
        void'($urandom(seed));
        for (int k = 0; k < 300; k++) apply(8'($urandom));
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule